// File: doc/BRIEF.md
# MII Carrier-Sense and Collision Generator

This block drives the carrier-sense (CRS) and collision (COL) signals that a 10/100 Ethernet PHY presents to its MAC. It takes the MAC's transmit enable, a receive-activity flag, a link-good flag and the serial receive bit stream, together with speed, duplex and heartbeat configuration bits and a one-cycle tick per line bit time. All timing inside the block is counted in those ticks.

At 10 Mb/s the receive carrier is the receive-activity flag. At 100 Mb/s the carrier is found in the serial stream: with the link good, a zero, then at least one one, then another zero. It holds until the packet ends. A collision exists in half duplex whenever transmit and receive carrier overlap. It is reported at once unless the local transmitter started first at 10 Mb/s, in which case seven bit ticks must pass first. With heartbeat enabled at 10 Mb/s half duplex, a test pulse is placed on COL a short gap after every transmission.

Top module: `mii_crs_col`

## Requirements
- R1: At 10 Mb/s half duplex, when `tx_en` rises while receive carrier is already present, `col` is high in the cycle after the rise.
- R2: At 10 Mb/s half duplex, when the collision begins with transmit already active (or both starting together), `col` stays low until the seventh `bit_tick` seen during the collision, and is high in the cycle after that seventh tick.
- R3: If transmit or receive activity drops before the seven ticks complete, the tick count is discarded. A later collision needs seven fresh ticks.
- R4: At 100 Mb/s half duplex, `col` rises one cycle after the overlap begins, with no tick count.
- R5: `col` stays high for as long as the overlap lasts. It is low in the cycle after the overlap ends, unless a heartbeat pulse is running.
- R6: With `cfg_full_dup` = 1, `col` is never asserted, neither for overlap nor for heartbeat.
- R7: With `cfg_hb_en` = 1 at 10 Mb/s half duplex, after `tx_en` falls `col` goes high once 10 ticks have passed. It stays high for 10 ticks and then falls. A new `tx_en` cancels a pending or running pulse.
- R8: No heartbeat pulse appears when `cfg_hb_en` = 0 or `cfg_speed100` = 1.
- R9: At 100 Mb/s, receive carrier needs `link_ok` = 1 and, sampled on ticks, a zero bit, then one or more ones, then a zero bit. Adjacent zeros alone do not qualify. Losing `link_ok` drops the carrier.
- R10: `crs` follows one cycle after its inputs. In half duplex it is receive carrier OR `tx_en`; in full duplex it is receive carrier only.
- R11: At 10 Mb/s, `crs` falls when `rx_active` falls. At 100 Mb/s, the carrier ends on a falling edge of `rx_active` (end of packet), and `crs` is low one cycle after that.
- R12: While `rst_n` is low at a clock edge, `crs` and `col` are low after that edge, and all counters are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_en | input | 1 | Transmit enable from the MAC |
| rx_active | input | 1 | Receive activity; its falling edge marks end of packet |
| rx_bit | input | 1 | Serial receive bit, sampled on `bit_tick` (100 Mb/s carrier search) |
| link_ok | input | 1 | Link valid flag |
| bit_tick | input | 1 | One-cycle pulse per line bit time |
| cfg_speed100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| cfg_full_dup | input | 1 | 1 = full duplex |
| cfg_hb_en | input | 1 | Heartbeat (SQE test pulse) enable |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision, including the heartbeat pulse |

## Verification
The assertions assume that `bit_tick` never appears in the same cycle as a collision onset or a `tx_en` fall, so that the first tick counted is a later one. They also assume that configuration bits change only while the line is idle and that `rx_active` rises within each 100 Mb/s packet. The stimulus follows these rules: configuration is changed only around a reset, ticks are issued in cycles of their own, and each overlap or packet is opened and closed in separate cycles. Within those limits the ordering of transmit against receive, the carrier bit patterns and link loss are varied.

// File: rtl/mii_cs_pkg.sv
// Shared state types for the MII carrier-sense and collision block.
package mii_cs_pkg;
    // Heartbeat sequencer states.
    typedef enum logic [1:0] {HB_IDLE, HB_GAP, HB_PULSE} hb_state_e;
    // 100 Mb/s carrier pattern search states.
    typedef enum logic [1:0] {PAT_IDLE, PAT_ZERO, PAT_ZERO_ONE} pat_state_e;
endpackage

// File: rtl/mii_rx_carrier.sv
// Receive carrier source.
// At 10 Mb/s: passes rx_active through.
// At 100 Mb/s: with link_ok, searches the ticked bit stream for a zero, one or
// more ones, then a zero. The carrier holds until rx_active falls or the link drops.
// Assumes: rx_bit is only meaningful in cycles with bit_tick.
module mii_rx_carrier
    import mii_cs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic speed100,
    input  logic link_ok,
    input  logic rx_active,
    input  logic rx_bit,
    input  logic bit_tick,
    output logic rx_carr
);
    logic       act_q;
    logic       car100;
    pat_state_e pat;
    logic       pkt_end;

    assign pkt_end = act_q & ~rx_active;

    // Remember last rx_active to find end of packet.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= rx_active;
    end

    // Pattern search and carrier hold for 100 Mb/s.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            car100 <= 1'b0;
            pat    <= PAT_IDLE;
        end else if (!speed100 || !link_ok) begin
            car100 <= 1'b0;
            pat    <= PAT_IDLE;
        end else if (car100) begin
            pat <= PAT_IDLE;
            if (pkt_end) car100 <= 1'b0;
        end else if (bit_tick) begin
            case (pat)
                PAT_IDLE:     if (!rx_bit) pat <= PAT_ZERO;
                PAT_ZERO:     if (rx_bit)  pat <= PAT_ZERO_ONE;
                PAT_ZERO_ONE: if (!rx_bit) begin
                    car100 <= 1'b1;
                    pat    <= PAT_IDLE;
                end
                default:      pat <= PAT_IDLE;
            endcase
        end
    end

    assign rx_carr = speed100 ? car100 : rx_active;

    AST_CAR_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        !link_ok |=> !car100); // R9
    AST_CAR_ADJ_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        (pat == PAT_ZERO && !car100) |=> !car100); // R9
endmodule

// File: rtl/mii_col_qual.sv
// Collision qualifier.
// Overlap of tx_en and receive carrier in half duplex is a collision.
// At 10 Mb/s, when transmit was first, COL waits QUAL_BITS ticks; otherwise
// it is immediate. The count restarts whenever the overlap breaks.
// Assumes: no bit_tick in the onset cycle of a collision.
module mii_col_qual #(
    parameter int QUAL_BITS = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic speed100,
    input  logic full_dup,
    input  logic tx_en,
    input  logic rx_carr,
    input  logic bit_tick,
    output logic coll_on
);
    localparam int QW = $clog2(QUAL_BITS + 1);

    logic          raw, raw_q, rx_q, onset, pending;
    logic [QW-1:0] cnt;

    assign raw   = ~full_dup & tx_en & rx_carr;
    assign onset = raw & ~raw_q;

    // Previous-cycle overlap and receive carrier, to classify the onset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
            rx_q  <= 1'b0;
        end else begin
            raw_q <= raw;
            rx_q  <= rx_carr;
        end
    end

    // Qualification counter and collision state.
    always_ff @(posedge clk) begin
        if (!rst_n || !raw) begin
            coll_on <= 1'b0;
            pending <= 1'b0;
            cnt     <= '0;
        end else if (onset) begin
            if (speed100 || rx_q) begin
                coll_on <= 1'b1;
                pending <= 1'b0;
                cnt     <= '0;
            end else begin
                pending <= 1'b1;
                cnt     <= QW'(bit_tick);
            end
        end else if (pending && bit_tick) begin
            if (cnt == QW'(QUAL_BITS - 1)) begin
                coll_on <= 1'b1;
                pending <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_COL_RX_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (onset && rx_q) |=> coll_on); // R1
    AST_COL_QUAL_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !bit_tick) |=> !coll_on); // R2
    AST_COL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_on && raw) |=> coll_on); // R5
    AST_COL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !coll_on); // R5
    AST_COL_FD_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        full_dup |=> !coll_on); // R6
endmodule

// File: rtl/mii_sqe_gen.sv
// Heartbeat (SQE test) pulse generator.
// After tx_en falls, waits GAP_TICKS ticks, then holds sqe_on for LEN_TICKS
// ticks. Any tx_en or loss of enable returns to idle.
// Assumes: enable already folds in heartbeat, 10 Mb/s and half duplex.
module mii_sqe_gen
    import mii_cs_pkg::*;
#(
    parameter int GAP_TICKS = 10,
    parameter int LEN_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tx_en,
    input  logic bit_tick,
    output logic sqe_on
);
    localparam int MAXT = (GAP_TICKS > LEN_TICKS) ? GAP_TICKS : LEN_TICKS;
    localparam int CW   = $clog2(MAXT + 1);

    hb_state_e     st;
    logic [CW-1:0] cnt;
    logic          tx_q;

    // Previous tx_en, to see the end of a transmission.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_q <= 1'b0;
        else        tx_q <= tx_en;
    end

    // Gap and pulse sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || tx_en) begin
            st  <= HB_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                HB_IDLE: if (tx_q) begin
                    st  <= HB_GAP;
                    cnt <= '0;
                end
                HB_GAP: if (bit_tick) begin
                    if (cnt == CW'(GAP_TICKS - 1)) begin
                        st  <= HB_PULSE;
                        cnt <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                HB_PULSE: if (bit_tick) begin
                    if (cnt == CW'(LEN_TICKS - 1)) begin
                        st  <= HB_IDLE;
                        cnt <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                default: st <= HB_IDLE;
            endcase
        end
    end

    assign sqe_on = (st == HB_PULSE);

    AST_HB_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !sqe_on); // R8
    AST_HB_NOT_IN_TX: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |=> !sqe_on); // R7
    AST_HB_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (sqe_on && !bit_tick && enable && !tx_en) |=> sqe_on); // R7
endmodule

// File: rtl/mii_crs_col.sv
// MII carrier-sense and collision generator (top).
// Combines receive carrier, collision qualification and heartbeat into the
// CRS and COL outputs. CRS is registered; COL is the OR of two registers.
// Assumes: configuration bits change only while the line is idle.
module mii_crs_col #(
    parameter int QUAL_BITS = 7,
    parameter int GAP_TICKS = 10,
    parameter int LEN_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic rx_active,
    input  logic rx_bit,
    input  logic link_ok,
    input  logic bit_tick,
    input  logic cfg_speed100,
    input  logic cfg_full_dup,
    input  logic cfg_hb_en,
    output logic crs,
    output logic col
);
    logic rx_carr, coll_on, sqe_on, hb_enable;

    assign hb_enable = cfg_hb_en & ~cfg_speed100 & ~cfg_full_dup;

    mii_rx_carrier u_carrier (
        .clk       (clk),
        .rst_n     (rst_n),
        .speed100  (cfg_speed100),
        .link_ok   (link_ok),
        .rx_active (rx_active),
        .rx_bit    (rx_bit),
        .bit_tick  (bit_tick),
        .rx_carr   (rx_carr)
    );

    mii_col_qual #(.QUAL_BITS(QUAL_BITS)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .speed100 (cfg_speed100),
        .full_dup (cfg_full_dup),
        .tx_en    (tx_en),
        .rx_carr  (rx_carr),
        .bit_tick (bit_tick),
        .coll_on  (coll_on)
    );

    mii_sqe_gen #(.GAP_TICKS(GAP_TICKS), .LEN_TICKS(LEN_TICKS)) u_sqe (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (hb_enable),
        .tx_en    (tx_en),
        .bit_tick (bit_tick),
        .sqe_on   (sqe_on)
    );

    // Carrier sense: receive carrier, plus own transmit in half duplex.
    always_ff @(posedge clk) begin
        if (!rst_n) crs <= 1'b0;
        else        crs <= rx_carr | (tx_en & ~cfg_full_dup);
    end

    assign col = coll_on | sqe_on;

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!col && !crs)); // R12
    AST_CRS_HALF_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_full_dup && tx_en) |=> crs); // R10
    AST_FD_NO_COL: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_full_dup |=> !col); // R6
endmodule

// File: tb/mii_crs_col_test.sv
module mii_crs_col_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b0, rx_active = 1'b0, rx_bit = 1'b1, link_ok = 1'b0;
    logic bit_tick = 1'b0;
    logic cfg_speed100 = 1'b0, cfg_full_dup = 1'b0, cfg_hb_en = 1'b0;
    logic crs, col;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit    ck_col;
        bit    e_col;
        bit    ck_crs;
        bit    e_crs;
        string rq;
    } exp_t;
    exp_t sbq[$];

    always #10 clk = ~clk;

    mii_crs_col uut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_active(rx_active),
        .rx_bit(rx_bit), .link_ok(link_ok), .bit_tick(bit_tick),
        .cfg_speed100(cfg_speed100), .cfg_full_dup(cfg_full_dup),
        .cfg_hb_en(cfg_hb_en), .crs(crs), .col(col)
    );

    // Monitor: pop one expectation per clock, 5 ns after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sbq.size() > 0) begin
                exp_t it;
                it = sbq.pop_front();
                if (it.ck_col) begin
                    checks++;
                    if (col !== it.e_col) begin
                        errors++;
                        $display("FAIL %s col actual=%b expected=%b t=%0t", it.rq, col, it.e_col, $time);
                    end
                end
                if (it.ck_crs) begin
                    checks++;
                    if (crs !== it.e_crs) begin
                        errors++;
                        $display("FAIL %s crs actual=%b expected=%b t=%0t", it.rq, crs, it.e_crs, $time);
                    end
                end
            end
        end
    end

    // Driver step: set tick, queue the expectation for the next edge, advance.
    task automatic cyc(input bit tk, input bit cc, input bit ec,
                       input bit cr, input bit er, input string rq);
        exp_t it;
        bit_tick = tk;
        it.ck_col = cc; it.e_col = ec; it.ck_crs = cr; it.e_crs = er; it.rq = rq;
        sbq.push_back(it);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tx_en = 1'b0; rx_active = 1'b0; rx_bit = 1'b1;
        cyc(0, 1, 0, 1, 0, "R12");
        cyc(0, 0, 0, 0, 0, "R12");
        rst_n = 1'b1;
    endtask

    task automatic send_bit(input bit b, input bit ec, input bit er, input string rq);
        rx_bit = b;
        cyc(1, 1, ec, 1, er, rq);
        cyc(0, 1, ec, 1, er, rq);
    endtask

    initial begin
        @(negedge clk);
        // R12: reset while activity is present.
        rst_n = 1'b0; tx_en = 1'b1; rx_active = 1'b1;
        cyc(0, 1, 0, 1, 0, "R12");
        cyc(0, 1, 0, 1, 0, "R12");
        do_reset();

        // R10 / R11: half duplex CRS at 10 Mb/s.
        tx_en = 1'b1; cyc(0, 1, 0, 1, 1, "R10");
        tx_en = 1'b0; cyc(0, 1, 0, 1, 0, "R10");
        rx_active = 1'b1; cyc(0, 1, 0, 1, 1, "R10");
        rx_active = 1'b0; cyc(0, 1, 0, 1, 0, "R11");

        // R6 / R10: full duplex, overlap and heartbeat never reach COL.
        cfg_full_dup = 1'b1; cfg_hb_en = 1'b1; do_reset();
        tx_en = 1'b1; cyc(0, 1, 0, 1, 0, "R10");
        rx_active = 1'b1; cyc(0, 1, 0, 1, 1, "R6");
        for (int i = 0; i < 9; i++) cyc(1, 1, 0, 1, 1, "R6");
        tx_en = 1'b0; rx_active = 1'b0; cyc(0, 1, 0, 1, 0, "R6");
        for (int i = 0; i < 25; i++) cyc(1, 1, 0, 0, 0, "R6");
        cfg_full_dup = 1'b0; cfg_hb_en = 1'b0; do_reset();

        // R1 / R5: receive first at 10 Mb/s gives an immediate collision.
        rx_active = 1'b1; cyc(0, 1, 0, 1, 1, "R1");
        tx_en = 1'b1; cyc(0, 1, 1, 1, 1, "R1");
        for (int i = 0; i < 3; i++) cyc(i == 1, 1, 1, 1, 1, "R5");
        rx_active = 1'b0; cyc(0, 1, 0, 1, 1, "R5");
        tx_en = 1'b0; cyc(0, 1, 0, 1, 0, "R11");

        // R2: transmit first at 10 Mb/s waits seven ticks.
        do_reset();
        tx_en = 1'b1; cyc(0, 1, 0, 1, 1, "R2");
        rx_active = 1'b1; cyc(0, 1, 0, 1, 1, "R2");
        for (int i = 0; i < 6; i++) begin
            cyc(1, 1, 0, 1, 1, "R2");
            cyc(0, 1, 0, 1, 1, "R2");
        end
        cyc(1, 1, 1, 1, 1, "R2");
        cyc(0, 1, 1, 1, 1, "R5");
        tx_en = 1'b0; cyc(0, 1, 0, 1, 1, "R5");
        rx_active = 1'b0; cyc(0, 1, 0, 1, 0, "R11");

        // R3: broken overlap discards the partial count.
        do_reset();
        tx_en = 1'b1; cyc(0, 1, 0, 1, 1, "R3");
        rx_active = 1'b1; cyc(0, 1, 0, 1, 1, "R3");
        for (int i = 0; i < 5; i++) cyc(1, 1, 0, 1, 1, "R3");
        rx_active = 1'b0; cyc(0, 1, 0, 1, 1, "R3");
        rx_active = 1'b1; cyc(0, 1, 0, 1, 1, "R3");
        for (int i = 0; i < 6; i++) cyc(1, 1, 0, 1, 1, "R3");
        cyc(1, 1, 1, 1, 1, "R3");
        tx_en = 1'b0; rx_active = 1'b0; cyc(0, 1, 0, 0, 0, "R5");

        // R4: 100 Mb/s collision, transmit first, no qualification.
        cfg_speed100 = 1'b1; link_ok = 1'b1; do_reset();
        tx_en = 1'b1; cyc(0, 1, 0, 1, 1, "R4");
        send_bit(1'b0, 0, 1, "R4");
        send_bit(1'b1, 0, 1, "R4");
        rx_bit = 1'b0; cyc(1, 1, 0, 1, 1, "R4");
        rx_active = 1'b1; cyc(0, 1, 1, 1, 1, "R4");
        cyc(0, 1, 1, 1, 1, "R5");
        tx_en = 1'b0; cyc(0, 1, 0, 1, 1, "R5");
        rx_active = 1'b0; cyc(0, 1, 0, 1, 1, "R11");
        cyc(0, 1, 0, 1, 0, "R11");

        // R9 / R11: 100 Mb/s carrier search in full duplex.
        cfg_full_dup = 1'b1; link_ok = 1'b0; do_reset();
        send_bit(1'b0, 0, 0, "R9");
        send_bit(1'b1, 0, 0, "R9");
        send_bit(1'b0, 0, 0, "R9");
        link_ok = 1'b1;
        send_bit(1'b0, 0, 0, "R9");
        send_bit(1'b0, 0, 0, "R9");
        send_bit(1'b0, 0, 0, "R9");
        send_bit(1'b1, 0, 0, "R9");
        send_bit(1'b1, 0, 0, "R9");
        rx_bit = 1'b0; cyc(1, 1, 0, 1, 0, "R9");
        rx_active = 1'b1; cyc(0, 1, 0, 1, 1, "R9");
        cyc(0, 1, 0, 1, 1, "R11");
        rx_active = 1'b0; cyc(0, 1, 0, 1, 1, "R11");
        cyc(0, 1, 0, 1, 0, "R11");
        send_bit(1'b0, 0, 0, "R9");
        send_bit(1'b1, 0, 0, "R9");
        rx_bit = 1'b0; cyc(1, 1, 0, 1, 0, "R9");
        cyc(0, 1, 0, 1, 1, "R9");
        link_ok = 1'b0; cyc(0, 1, 0, 1, 1, "R9");
        cyc(0, 1, 0, 1, 0, "R9");

        // R7: heartbeat after a 10 Mb/s half duplex transmission.
        cfg_speed100 = 1'b0; cfg_full_dup = 1'b0; cfg_hb_en = 1'b1; do_reset();
        tx_en = 1'b1; cyc(0, 1, 0, 1, 1, "R7");
        tx_en = 1'b0; cyc(0, 1, 0, 1, 0, "R7");
        for (int i = 0; i < 9; i++) begin
            cyc(1, 1, 0, 0, 0, "R7");
            cyc(0, 1, 0, 0, 0, "R7");
        end
        cyc(1, 1, 1, 0, 0, "R7");
        for (int i = 0; i < 9; i++) begin
            cyc(0, 1, 1, 0, 0, "R7");
            cyc(1, 1, 1, 0, 0, "R7");
        end
        cyc(0, 1, 1, 0, 0, "R7");
        cyc(1, 1, 0, 0, 0, "R7");
        cyc(0, 1, 0, 1, 0, "R7");
        // R7: a new transmission cancels a pending pulse.
        tx_en = 1'b1; cyc(0, 1, 0, 1, 1, "R7");
        tx_en = 1'b0; cyc(0, 1, 0, 1, 0, "R7");
        for (int i = 0; i < 5; i++) cyc(1, 1, 0, 0, 0, "R7");
        tx_en = 1'b1; cyc(0, 1, 0, 1, 1, "R7");
        for (int i = 0; i < 8; i++) cyc(1, 1, 0, 1, 1, "R7");
        tx_en = 1'b0; cyc(0, 1, 0, 1, 0, "R7");
        for (int i = 0; i < 9; i++) cyc(1, 1, 0, 0, 0, "R7");
        cyc(1, 1, 1, 0, 0, "R7");
        for (int i = 0; i < 10; i++) cyc(1, 0, 0, 0, 0, "R7");

        // R8: no heartbeat when disabled, nor at 100 Mb/s.
        cfg_hb_en = 1'b0; do_reset();
        tx_en = 1'b1; cyc(0, 1, 0, 1, 1, "R8");
        tx_en = 1'b0; cyc(0, 1, 0, 1, 0, "R8");
        for (int i = 0; i < 25; i++) cyc(1, 1, 0, 0, 0, "R8");
        cfg_hb_en = 1'b1; cfg_speed100 = 1'b1; do_reset();
        tx_en = 1'b1; cyc(0, 1, 0, 1, 1, "R8");
        tx_en = 1'b0; cyc(0, 1, 0, 1, 0, "R8");
        for (int i = 0; i < 25; i++) cyc(1, 1, 0, 0, 0, "R8");

        cyc(0, 0, 0, 0, 0, "R12");
        cyc(0, 0, 0, 0, 0, "R12");
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        for (int i = 0; i < 200000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule